// File: doc/BRIEF.md
# Sector Protection Pulse-and-Verify Sequencer

This block sits on the host side of a flash command port and locks one or more sectors against erase and program. When started, it captures a short list of sector numbers. It asks for the elevated voltage on the device's reset pin and lets that voltage settle for a fixed time. It then arms the device with one setup command.

For each listed sector the block writes a protect command and waits a long fixed pulse time. It then writes a verify command and reads back a status byte. If the status byte does not report the sector as locked, the block pulses that sector again, up to a bounded number of tries. Once the whole list is locked, or once a sector exhausts its tries, the block releases the high-voltage request. It then writes the return-to-read command and reports the outcome. On failure the report names the position of the failing sector in the list.

All waits are counted in clock cycles, derived from a clock-frequency parameter given in MHz. The command port is a plain request/acknowledge bus master. Generating the high voltage is left to circuitry outside this block.

Top module: `secprot_seq`

## Requirements
- R1: After synchronous reset, `hv_en`, `req`, `busy`, `done` and `ok` are 0 and `fail_idx` is 0.
- R2: `hv_en` and `busy` rise in the cycle after `start` is sampled with a non-zero `sect_cnt`. The first request rises exactly SETTLE_US*CLK_MHZ cycles after `hv_en`. That request is a write of 60h to address 0.
- R3: While `req` is high and `ack` is low, `we`, `addr` and `wdata` stay stable. A transfer completes on the clock edge where `req` and `ack` are both high. `req` is low for at least the next cycle.
- R4: Each protect pulse is a write of 60h to `{sector, low part}`. The sector number fills the top SECT_W address bits. The low part is 0x002, so bit 6 = 0, bit 1 = 1 and bit 0 = 0. The verify write of 40h to the same address starts exactly PROT_US*CLK_MHZ cycles after the protect write completes.
- R5: One idle cycle after the verify write completes, the block reads the same address (`we`=0). Only the read value 01h counts as protected. Every other value, such as 00h or 81h, counts as not protected.
- R6: A read that is not 01h starts a new protect pulse on the same sector after one idle cycle. A sector that still reads not-protected after MAX_PULSE (25) pulses ends the run as a failure.
- R7: After a sector reads 01h, any remaining listed sector is pulsed next, starting from a count of 1. No second setup write is issued in that run. List entry i sits at `sect_list[i*SECT_W +: SECT_W]`, and entries 0 to `sect_cnt`-1 are used in order.
- R8: `hv_en` falls on the edge that completes the final read. After one idle cycle the block writes F0h to address 0. When that write completes, `done` pulses for one cycle and `busy` falls. `ok` is 1 on success. On failure `ok` is 0 and `fail_idx` gives the list position of the failing sector. Both hold until the next start.
- R9: A `start` with `sect_cnt` = 0 gives `done` and `ok` = 1 in the next cycle. Neither `hv_en` nor `req` is raised.
- R10: While `busy` is high, `start` pulses and changes to `sect_list` or `sect_cnt` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a protection run (ignored while busy) |
| sect_cnt | input | CNT_W (3) | Number of list entries to protect |
| sect_list | input | MAX_SECT*SECT_W (28) | Packed sector numbers, entry i at i*SECT_W |
| ack | input | 1 | Bus acknowledge, completes the current transfer |
| rdata | input | 8 | Read data, valid with `ack` on a read |
| hv_en | output | 1 | Request for high voltage on the flash reset pin |
| req | output | 1 | Bus request |
| we | output | 1 | 1 = write, 0 = read |
| addr | output | ADDR_W (19) | Bus address |
| wdata | output | 8 | Write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Result of the last run: all sectors locked |
| fail_idx | output | IDX_W (2) | List position of the sector that failed |

## Verification
The hardest situation to reach is exhausting the pulse limit on a sector that is not first in the list, while the status byte it returns is non-zero but not 01h. The bench's acknowledge responder models the device. It reports a sector as locked only after a scripted number of protect writes to that sector address, and it returns a chosen wrong value before that. Giving the second sector a script that never completes drives the run through all 25 pulses and into the failure report with index 1. A separate run changes the list and pulses `start` while the block is busy.

// File: rtl/secprot_pkg.sv
package secprot_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_LAUNCH, ST_BUS, ST_PWAIT} state_t;
  typedef enum logic [2:0] {OP_SETUP, OP_PROT, OP_VERW, OP_READ, OP_RESET} op_t;

  localparam logic [7:0] CMD_ARM   = 8'h60;
  localparam logic [7:0] CMD_PULSE = 8'h60;
  localparam logic [7:0] CMD_CHECK = 8'h40;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;
  localparam logic [7:0] STAT_LOCK = 8'h01;
endpackage

// File: rtl/secprot_tmr.sv
module secprot_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(val)));  // R4
endmodule

// File: rtl/secprot_bus.sv
module secprot_bus #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [7:0]        l_data,
  input  logic              ack,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              xfer
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (launch) begin
      req   <= 1'b1;
      we    <= l_we;
      addr  <= l_addr;
      wdata <= l_data;
    end else if (req && ack) begin
      req   <= 1'b0;
    end
  end

  assign xfer = req & ack;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(we) && $stable(addr) && $stable(wdata)));  // R3
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);  // R3
endmodule

// File: rtl/secprot_seq.sv
module secprot_seq
  import secprot_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 4,
  parameter int PROT_US   = 150,
  parameter int MAX_PULSE = 25,
  parameter int MAX_SECT  = 4,
  parameter int ADDR_W    = 19,
  parameter int SECT_W    = 7,
  localparam int CNT_W    = $clog2(MAX_SECT + 1),
  localparam int IDX_W    = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [CNT_W-1:0]           sect_cnt,
  input  logic [MAX_SECT*SECT_W-1:0] sect_list,
  input  logic                       ack,
  input  logic [7:0]                 rdata,
  output logic                       hv_en,
  output logic                       req,
  output logic                       we,
  output logic [ADDR_W-1:0]          addr,
  output logic [7:0]                 wdata,
  output logic                       busy,
  output logic                       done,
  output logic                       ok,
  output logic [IDX_W-1:0]           fail_idx
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int PROT_CYC   = CLK_MHZ * PROT_US;
  localparam int TMR_MAX    = (SETTLE_CYC > PROT_CYC) ? SETTLE_CYC : PROT_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int PC_W       = $clog2(MAX_PULSE + 1);
  localparam int LOW_W      = ADDR_W - SECT_W;
  localparam logic [LOW_W-1:0] LOW_PART = LOW_W'(2);

  state_t            state;
  op_t               pend, cur_op, l_op;
  logic [SECT_W-1:0] list_q [MAX_SECT];
  logic [CNT_W-1:0]  n_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PC_W-1:0]   pcnt_q;
  logic              res_ok;
  logic              tmr_load, tmr_zero, launch, xfer, last;
  logic [TMR_W-1:0]  tmr_val;
  logic              l_we;
  logic [ADDR_W-1:0] l_addr, sect_addr;
  logic [7:0]        l_data;

  assign sect_addr = {list_q[idx_q], LOW_PART};
  assign last      = (CNT_W'(idx_q) + 1'b1) == n_q;

  assign tmr_load = (state == ST_IDLE && start && sect_cnt != '0) ||
                    (state == ST_BUS && xfer && cur_op == OP_PROT);
  assign tmr_val  = (state == ST_IDLE) ? TMR_W'(SETTLE_CYC - 1) : TMR_W'(PROT_CYC - 1);

  assign launch = (state == ST_LAUNCH) || (tmr_zero && (state == ST_SETTLE || state == ST_PWAIT));
  assign l_op   = (state == ST_SETTLE) ? OP_SETUP : (state == ST_PWAIT) ? OP_VERW : pend;

  always_comb begin
    l_we   = 1'b1;
    l_addr = '0;
    l_data = CMD_ARM;
    unique case (l_op)
      OP_SETUP: begin l_addr = '0;        l_data = CMD_ARM;   end
      OP_PROT:  begin l_addr = sect_addr; l_data = CMD_PULSE; end
      OP_VERW:  begin l_addr = sect_addr; l_data = CMD_CHECK; end
      OP_READ:  begin l_addr = sect_addr; l_data = 8'h00; l_we = 1'b0; end
      OP_RESET: begin l_addr = '0;        l_data = CMD_EXIT;  end
      default:  begin l_addr = '0;        l_data = CMD_EXIT;  end
    endcase
  end

  secprot_tmr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  secprot_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .launch(launch), .l_we(l_we), .l_addr(l_addr),
    .l_data(l_data), .ack(ack), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .xfer(xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= OP_SETUP;
      cur_op   <= OP_SETUP;
      hv_en    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      fail_idx <= '0;
      idx_q    <= '0;
      n_q      <= '0;
      pcnt_q   <= '0;
      res_ok   <= 1'b0;
      for (int i = 0; i < MAX_SECT; i++) list_q[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          fail_idx <= '0;
          if (sect_cnt == '0) begin
            done <= 1'b1;
            ok   <= 1'b1;
          end else begin
            for (int i = 0; i < MAX_SECT; i++) list_q[i] <= sect_list[i*SECT_W +: SECT_W];
            n_q    <= (sect_cnt > CNT_W'(MAX_SECT)) ? CNT_W'(MAX_SECT) : sect_cnt;
            idx_q  <= '0;
            pcnt_q <= PC_W'(1);
            hv_en  <= 1'b1;
            busy   <= 1'b1;
            ok     <= 1'b0;
            state  <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (tmr_zero) begin cur_op <= OP_SETUP; state <= ST_BUS; end
        ST_PWAIT:  if (tmr_zero) begin cur_op <= OP_VERW;  state <= ST_BUS; end
        ST_LAUNCH: begin cur_op <= pend; state <= ST_BUS; end
        ST_BUS: if (xfer) begin
          unique case (cur_op)
            OP_SETUP: begin pend <= OP_PROT; state <= ST_LAUNCH; end
            OP_PROT:  state <= ST_PWAIT;
            OP_VERW:  begin pend <= OP_READ; state <= ST_LAUNCH; end
            OP_READ: begin
              state <= ST_LAUNCH;
              if (rdata == STAT_LOCK) begin
                if (last) begin
                  res_ok <= 1'b1;
                  hv_en  <= 1'b0;
                  pend   <= OP_RESET;
                end else begin
                  idx_q  <= idx_q + 1'b1;
                  pcnt_q <= PC_W'(1);
                  pend   <= OP_PROT;
                end
              end else if (pcnt_q == PC_W'(MAX_PULSE)) begin
                res_ok <= 1'b0;
                hv_en  <= 1'b0;
                pend   <= OP_RESET;
              end else begin
                pcnt_q <= pcnt_q + 1'b1;
                pend   <= OP_PROT;
              end
            end
            OP_RESET: begin
              busy     <= 1'b0;
              done     <= 1'b1;
              ok       <= res_ok;
              fail_idx <= res_ok ? '0 : idx_q;
              state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> !req);  // R2
  AST_HV_FOR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (req && cur_op != OP_SETUP && cur_op != OP_RESET) |-> hv_en);  // R4
  AST_PULSE_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pcnt_q >= PC_W'(1) && pcnt_q <= PC_W'(MAX_PULSE)));  // R6
  AST_EXIT_NO_HV: assert property (@(posedge clk) disable iff (rst)
    (req && we && wdata == CMD_EXIT) |-> !hv_en);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req && !hv_en));  // R9
endmodule

// File: tb/secprot_seq_bench.sv
module secprot_seq_bench;
  localparam int CLK_MHZ = 2;
  localparam int NS = CLK_MHZ * 4;
  localparam int NP = CLK_MHZ * 150;
  localparam int MAXP = 25;
  localparam int MAX_SECT = 4;
  localparam int ADDR_W = 19;
  localparam int SECT_W = 7;
  localparam int CNT_W = 3;
  localparam int IDX_W = 2;
  localparam int LOW_W = ADDR_W - SECT_W;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ack = 1'b0;
  logic [CNT_W-1:0] sect_cnt = '0;
  logic [MAX_SECT*SECT_W-1:0] sect_list = '0;
  logic [7:0] rdata = 8'h00;
  logic hv_en, req, we, busy, done, ok;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata;
  logic [IDX_W-1:0] fail_idx;

  always #2 clk = ~clk;

  secprot_seq #(.CLK_MHZ(CLK_MHZ)) u_secprot_seq (
    .clk(clk), .rst(rst), .start(start), .sect_cnt(sect_cnt), .sect_list(sect_list),
    .ack(ack), .rdata(rdata), .hv_en(hv_en), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .ok(ok), .fail_idx(fail_idx)
  );

  int checks = 0, errors = 0;
  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // device responder
  int lat = 0, wcnt = 0, setup_cnt = 0, hv_seen = 0;
  int needed [128];
  int prot_cnt [128];
  logic [7:0] unprot_val = 8'h00;
  always @(negedge clk) begin
    if (rst) begin
      ack = 1'b0; wcnt = 0;
    end else if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      if (wcnt >= lat) begin
        int sv;
        sv = int'(addr[ADDR_W-1 -: SECT_W]);
        ack = 1'b1; wcnt = 0;
        if (we) begin
          if (wdata == 8'h60 && addr[LOW_W-1:0] == LOW_W'(2)) prot_cnt[sv]++;
          if (wdata == 8'h60 && addr == '0) setup_cnt++;
        end else begin
          rdata = (prot_cnt[sv] >= needed[sv]) ? 8'h01 : unprot_val;
        end
      end else wcnt++;
    end else wcnt = 0;
    if (hv_en) hv_seen++;
  end

  // behavioural reference model
  logic e_hv = 0, e_req = 0, e_we = 0, e_busy = 0, e_done = 0, e_ok = 0;
  logic [ADDR_W-1:0] e_addr = '0;
  logic [7:0] e_wdata = '0;
  int e_fidx = 0;

  task automatic m_bus(input bit w, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    e_req = 1; e_we = w; e_addr = a; e_wdata = d;
    forever begin
      @(posedge clk);
      if (ack) break;
    end
    e_req = 0;
    rd = rdata;
  endtask

  task automatic m_run();
    int n, idx, pc;
    bit pass;
    logic [SECT_W-1:0] lst [MAX_SECT];
    logic [7:0] rd;
    logic [ADDR_W-1:0] sa;
    n = (int'(sect_cnt) > MAX_SECT) ? MAX_SECT : int'(sect_cnt);
    for (int i = 0; i < MAX_SECT; i++) lst[i] = sect_list[i*SECT_W +: SECT_W];
    e_fidx = 0;
    if (n == 0) begin e_done = 1; e_ok = 1; return; end
    e_busy = 1; e_hv = 1; e_ok = 0;
    repeat (NS) @(posedge clk);
    m_bus(1, '0, 8'h60, rd);
    @(posedge clk);
    idx = 0; pc = 1;
    forever begin
      sa = {lst[idx], LOW_W'(2)};
      m_bus(1, sa, 8'h60, rd);
      repeat (NP) @(posedge clk);
      m_bus(1, sa, 8'h40, rd);
      @(posedge clk);
      m_bus(0, sa, 8'h00, rd);
      if (rd == 8'h01) begin
        if (idx + 1 == n) begin pass = 1; break; end
        idx++; pc = 1;
      end else if (pc == MAXP) begin
        pass = 0; break;
      end else pc++;
      @(posedge clk);
    end
    e_hv = 0;
    @(posedge clk);
    m_bus(1, '0, 8'hF0, rd);
    e_done = 1; e_busy = 0; e_ok = pass; e_fidx = pass ? 0 : idx;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      e_done = 0;
      if (rst) begin
        e_hv = 0; e_req = 0; e_busy = 0; e_ok = 0; e_fidx = 0;
      end else if (start) m_run();
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      check(hv_en == e_hv, "R2 hv_en", hv_en, e_hv);
      check(req == e_req, "R3 req", req, e_req);
      if (e_req) begin
        check(we == e_we, "R4 we", we, e_we);
        check(addr == e_addr, "R4 addr", addr, e_addr);
        if (e_we) check(wdata == e_wdata, "R4 wdata", wdata, e_wdata);
      end
      check(busy == e_busy, "R10 busy", busy, e_busy);
      check(done == e_done, "R8 done", done, e_done);
      check(ok == e_ok, "R8 ok", ok, e_ok);
      check(int'(fail_idx) == e_fidx, "R8 fail_idx", fail_idx, e_fidx);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check(0, "R8 done timeout", 0, 1);
  endtask

  task automatic clear_dev();
    for (int i = 0; i < 128; i++) begin needed[i] = 1; prot_cnt[i] = 0; end
    setup_cnt = 0; hv_seen = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_dev();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    check(!hv_en && !req && !busy && !done && !ok && fail_idx == 0, "R1 reset state",
          {hv_en, req, busy, done, ok}, 0);

    // R9: empty list
    sect_cnt = 0;
    pulse_start();
    check(done && ok, "R9 empty list done/ok", {done, ok}, 2'b11);
    repeat (3) @(negedge clk);
    check(hv_seen == 0, "R9 no high voltage", hv_seen, 0);

    // single sector locked on first pulse
    clear_dev(); lat = 0;
    sect_list = '0; sect_list[0 +: SECT_W] = 7'h05; sect_cnt = 1;
    pulse_start(); wait_done();
    check(ok == 1'b1, "R8 single sector ok", ok, 1);
    check(prot_cnt[5] == 1, "R5 one pulse for sector 5", prot_cnt[5], 1);

    // three sectors with retries, disturbance while busy
    clear_dev(); lat = 2;
    sect_list[0*SECT_W +: SECT_W] = 7'h12; needed[7'h12] = 3;
    sect_list[1*SECT_W +: SECT_W] = 7'h03; needed[7'h03] = 1;
    sect_list[2*SECT_W +: SECT_W] = 7'h7F; needed[7'h7F] = 2;
    sect_cnt = 3;
    pulse_start();
    repeat (50) @(negedge clk);
    sect_list = '0; sect_cnt = 1;   // R10: ignored mid-run
    pulse_start();
    wait_done();
    check(ok == 1'b1, "R10 run unaffected ok", ok, 1);
    check(prot_cnt[7'h12] == 3, "R6 retries on sector 12h", prot_cnt[7'h12], 3);
    check(prot_cnt[7'h03] == 1, "R7 second sector count restarts", prot_cnt[7'h03], 1);
    check(prot_cnt[7'h7F] == 2, "R7 third sector pulses", prot_cnt[7'h7F], 2);
    check(setup_cnt == 1, "R7 single setup write", setup_cnt, 1);
    check(prot_cnt[0] == 0, "R10 changed list not used", prot_cnt[0], 0);

    // failure on the second sector, wrong non-zero status
    repeat (5) @(negedge clk);
    clear_dev(); lat = 1; unprot_val = 8'h81;
    sect_list = '0;
    sect_list[0*SECT_W +: SECT_W] = 7'h20; needed[7'h20] = 1;
    sect_list[1*SECT_W +: SECT_W] = 7'h21; needed[7'h21] = 1000;
    sect_cnt = 2;
    pulse_start(); wait_done();
    check(ok == 1'b0, "R5 81h is not a lock", ok, 0);
    check(fail_idx == 2'd1, "R8 failing index", fail_idx, 1);
    check(prot_cnt[7'h21] == MAXP, "R6 pulse limit reached", prot_cnt[7'h21], MAXP);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule